// File: doc/BRIEF.md
# NAND flash bus sequencer

This block drives the asynchronous 8-bit bus that four raw NAND flash dies share. A host hands it one operation at a time through a valid/ready handshake. The operations are: choose one die, release all dies, latch a command byte, latch a run of address bytes, write a burst of data bytes, read a burst of data bytes, or flip the write-protect line. The block produces the four active-low die enables, the command and address latch strobes, the write and read strobes and write protect. It also drives and samples the shared data bus.

Write and address bytes arrive from the host on a per-byte valid/ready stream, and read bytes leave on another one. A one-cycle `done` pulse marks the end of every operation. The strobe low and high widths are parameters counted in clock cycles. For each read strobe the block waits for the sensed strobe level, fed back from the pad, before it moves on. The four ready/busy lines are combined into a single ready flag.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset all four die enables are high, the write and read strobes are high, the command and address latches are low, write protect is low (asserted), the data driver is off and `op_ready` is high.
- R2: Operation code 0 with `op_chip` in 0..3 drives only that die's enable low (bit i of `ce_n` belongs to die i). With `op_chip` in 4..7 it leaves `ce_n` unchanged. Code 1 drives all four enables high. At most one enable is ever low.
- R3: `flash_ready` is high exactly when all four `rb_n` lines are high.
- R4: Code 2 places `op_arg` on the bus with ALE low and `re_n` high and gives one `we_n` low pulse while CLE is high. CLE falls only after `we_n` has returned high.
- R5: Code 3 with `op_len` N>0 takes N bytes from the write stream and latches each with one `we_n` pulse while ALE is high and CLE low. ALE stays high from the first byte to the last and falls once, after the last.
- R6: Code 3 with `op_len` 0 still sends one address byte of value 0x00 with one `we_n` pulse.
- R7: Code 4 with `op_len` N takes N bytes from the write stream and clocks each with one `we_n` pulse while CLE and ALE are low and `re_n` is high.
- R8: Code 5 with `op_len` N reads N bytes with `we_n` high. For each byte `re_n` goes low, and the bus is sampled only after `re_sense` reads low. `re_n` then returns high, and the next byte starts only after `re_sense` reads high. The bytes leave in order on the read stream.
- R9: `dq_oe` is high only during command, address and write-data byte transfers, and it is never high while `re_n` is low.
- R10: Code 6 inverts `wp_n`, and `done` follows no sooner than 2 microseconds later (2×CLK_MHZ cycles).
- R11: An operation is accepted only while `op_ready` is high. Code 7 does nothing, and every operation ends with a `done` pulse exactly one cycle long.
- R12: Each `we_n` low phase lasts WE_LO_CYC cycles and each high phase WE_HI_CYC cycles. The bus value is driven at least one cycle before `we_n` falls and is held unchanged until after it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request valid |
| op_ready | output | 1 | Sequencer idle, request accepted this cycle |
| op_code | input | 3 | Operation code (see R2, R4 to R11) |
| op_chip | input | 3 | Die index for the select operation |
| op_arg | input | 8 | Command byte |
| op_len | input | LEN_W | Byte count for address, write and read |
| wr_valid | input | 1 | Write/address byte valid |
| wr_ready | output | 1 | Write/address byte taken |
| wr_data | input | 8 | Write/address byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-operation pulse |
| flash_ready | output | 1 | AND of all ready/busy lines |
| rb_n | input | 4 | Ready/busy lines of the four dies |
| ce_n | output | 4 | Active-low die enables |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| we_n | output | 1 | Active-low write strobe |
| re_n | output | 1 | Active-low read strobe |
| wp_n | output | 1 | Active-low write protect |
| re_sense | input | 1 | Sensed level of the read strobe at the pad |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | 8 | Data bus input value |

## Verification
The hardest case to reach is a read in which the sensed strobe lags the driven one. The sequencer must wait in both the low and the high phase, and a wrong sample would look correct unless the bus carries junk until the sensed level drops. The bench loops the read strobe back through a three-cycle delay line and drives 0xEE on the data bus while the sensed level is high. A premature sample or a premature next strobe then shows up in the read bytes and in the strobe count.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_SEL    = 3'd0,
        OP_DESEL  = 3'd1,
        OP_CMD    = 3'd2,
        OP_ADDR   = 3'd3,
        OP_WRITE  = 3'd4,
        OP_READ   = 3'd5,
        OP_WPTOG  = 3'd6,
        OP_NOP    = 3'd7
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_WLO,
        ST_WHI,
        ST_TAIL,
        ST_RLO,
        ST_RHI,
        ST_RPUSH,
        ST_SETTLE,
        ST_DONE
    } st_e;

    // Latched operation context
    typedef struct packed {
        op_e        code;
        logic [7:0] bus_byte;
    } op_ctx_t;

    function automatic logic [3:0] ce_pattern(input logic [1:0] idx);
        return ~(4'b0001 << idx);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/nand_ce_bank.sv
module nand_ce_bank
    import nand_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_en,
    input  logic       desel_en,
    input  logic [2:0] idx,
    output logic [3:0] ce_n
);
    always_ff @(posedge clk) begin
        if (rst)                      ce_n <= 4'hF;
        else if (desel_en)            ce_n <= 4'hF;
        else if (sel_en && !idx[2])   ce_n <= ce_pattern(idx[1:0]);
    end

    assert_ce_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(~ce_n) <= 1);

    assert_ce_range_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_en && idx[2]) |=> $stable(ce_n));

    assert_ce_desel_R2: assert property (@(posedge clk) disable iff (rst)
        desel_en |=> (ce_n == 4'hF));

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nand_seq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int WE_LO_CYC = 2,
    parameter int WE_HI_CYC = 2,
    parameter int CLK_MHZ   = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [2:0]       op_code,
    input  logic [2:0]       op_chip,
    input  logic [7:0]       op_arg,
    input  logic [LEN_W-1:0] op_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             flash_ready,
    input  logic [3:0]       rb_n,
    output logic [3:0]       ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic             wp_n,
    input  logic             re_sense,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    input  logic [7:0]       dq_in
);
    localparam int LO_C   = (WE_LO_CYC < 1) ? 1 : WE_LO_CYC;
    localparam int HI_C   = (WE_HI_CYC < 1) ? 1 : WE_HI_CYC;
    localparam int SETTLE = 2 * CLK_MHZ;
    localparam int MAXC   = max3(LO_C, HI_C, SETTLE);
    localparam int TW     = $clog2(MAXC + 1);

    st_e              st, nxt;
    op_ctx_t          ctx;
    op_e              req;
    logic [LEN_W-1:0] rem;
    logic [7:0]       rd_q;
    logic             wp_q;
    logic             tload, tzero;
    logic [TW-1:0]    tval;
    logic             accept, in_wr;

    assign req    = op_e'(op_code);
    assign accept = (st == ST_IDLE) && op_valid;

    nand_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(tload), .load_val(tval), .zero(tzero)
    );

    nand_ce_bank u_ce (
        .clk(clk), .rst(rst),
        .sel_en(accept && req == OP_SEL),
        .desel_en(accept && req == OP_DESEL),
        .idx(op_chip), .ce_n(ce_n)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (op_valid) begin
                unique case (req)
                    OP_CMD:   nxt = ST_SETUP;
                    OP_ADDR:  nxt = (op_len == '0) ? ST_SETUP : ST_FETCH;
                    OP_WRITE: nxt = (op_len == '0) ? ST_DONE  : ST_FETCH;
                    OP_READ:  nxt = (op_len == '0) ? ST_DONE  : ST_RLO;
                    OP_WPTOG: nxt = ST_SETTLE;
                    default:  nxt = ST_DONE;
                endcase
            end
            ST_FETCH:  if (wr_valid) nxt = ST_SETUP;
            ST_SETUP:  nxt = ST_WLO;
            ST_WLO:    if (tzero) nxt = ST_WHI;
            ST_WHI:    if (tzero)
                           nxt = ((ctx.code == OP_ADDR || ctx.code == OP_WRITE) && rem > 1)
                                 ? ST_FETCH : ST_TAIL;
            ST_TAIL:   nxt = ST_DONE;
            ST_RLO:    if (tzero && !re_sense) nxt = ST_RHI;
            ST_RHI:    if (tzero && re_sense)  nxt = ST_RPUSH;
            ST_RPUSH:  if (rd_ready) nxt = (rem > 1) ? ST_RLO : ST_DONE;
            ST_SETTLE: if (tzero) nxt = ST_DONE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        tload = (nxt != st);
        unique case (nxt)
            ST_WLO, ST_RLO: tval = TW'(LO_C - 1);
            ST_WHI, ST_RHI: tval = TW'(HI_C - 1);
            ST_SETTLE:      tval = TW'(SETTLE - 1);
            default:        tval = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            ctx  <= '{code: OP_NOP, bus_byte: 8'h00};
            rem  <= '0;
            rd_q <= 8'h00;
            wp_q <= 1'b0;
        end else begin
            st <= nxt;
            if (accept) begin
                ctx.code     <= req;
                ctx.bus_byte <= (req == OP_CMD) ? op_arg : 8'h00;
                rem          <= (req == OP_ADDR && op_len == '0) ? LEN_W'(1) : op_len;
                if (req == OP_WPTOG) wp_q <= ~wp_q;
            end
            if (st == ST_FETCH && wr_valid)          ctx.bus_byte <= wr_data;
            if (st == ST_WHI && nxt == ST_FETCH)     rem <= rem - 1'b1;
            if (st == ST_RLO && nxt == ST_RHI)       rd_q <= dq_in;
            if (st == ST_RPUSH && rd_ready)          rem <= rem - 1'b1;
        end
    end

    assign in_wr       = (st == ST_SETUP) || (st == ST_WLO) || (st == ST_WHI);
    assign op_ready    = (st == ST_IDLE);
    assign wr_ready    = (st == ST_FETCH);
    assign rd_valid    = (st == ST_RPUSH);
    assign rd_data     = rd_q;
    assign done        = (st == ST_DONE);
    assign dq_oe       = in_wr;
    assign dq_out      = ctx.bus_byte;
    assign we_n        = (st != ST_WLO);
    assign re_n        = (st != ST_RLO);
    assign cle         = (ctx.code == OP_CMD) && in_wr;
    assign ale         = (ctx.code == OP_ADDR) && (in_wr || st == ST_FETCH);
    assign wp_n        = wp_q;
    assign flash_ready = &rb_n;

    assert_latch_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    assert_cle_after_we_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(cle) |-> (we_n && $past(we_n)));

    assert_ale_no_read_R5: assert property (@(posedge clk) disable iff (rst)
        ale |-> re_n);

    assert_re_after_sense_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(re_n) |-> $past(!re_sense));

    assert_strobes_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(!re_n && !we_n));

    assert_bus_off_read_R9: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_setup_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> ($past(dq_oe) && $stable(dq_out)));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (dq_oe && $stable(dq_out)));

endmodule

// File: tb/nand_bus_seq_test.sv
module nand_bus_seq_test;
    import nand_seq_pkg::*;

    localparam int CLK_NS   = 10;
    localparam int LO_C     = 2;
    localparam int HI_C     = 2;
    localparam int MHZ      = 100;
    localparam int SETTLE   = 2 * MHZ;

    logic clk = 1'b0, rst = 1'b1;
    logic op_valid = 0, op_ready;
    logic [2:0] op_code = 0, op_chip = 0;
    logic [7:0] op_arg = 0, op_len = 0;
    logic wr_valid = 0, wr_ready;
    logic [7:0] wr_data = 0;
    logic rd_valid, rd_ready = 1'b1;
    logic [7:0] rd_data;
    logic done, flash_ready;
    logic [3:0] rb_n = 4'hF, ce_n;
    logic cle, ale, we_n, re_n, wp_n, re_sense, dq_oe;
    logic [7:0] dq_out, dq_in;

    int checks = 0, errors = 0, cyc = 0;

    nand_bus_seq #(.LEN_W(8), .WE_LO_CYC(LO_C), .WE_HI_CYC(HI_C), .CLK_MHZ(MHZ)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_chip(op_chip), .op_arg(op_arg), .op_len(op_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .flash_ready(flash_ready), .rb_n(rb_n), .ce_n(ce_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .wp_n(wp_n),
        .re_sense(re_sense), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Pad loopback model: sensed read strobe lags by three cycles
    logic [2:0] sdly = 3'b111;
    int rd_idx = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        sdly <= {sdly[1:0], re_n};
    end
    assign re_sense = sdly[2];
    assign dq_in = re_sense ? 8'hEE : (8'hA0 + 8'(rd_idx));

    // Bus monitor, sampled on the falling clock edge
    logic [7:0] lg_dat [64];
    logic       lg_cle [64];
    logic       lg_ale [64];
    int lg_n = 0, ale_falls = 0, oe_cnt = 0, re_lows = 0, done_cyc = 0;
    int lo_run = 0, lo_bad = 0;
    logic [7:0] rbuf [16];
    int rn = 0;
    logic we_p = 1, ale_p = 0, re_p = 1;
    always @(negedge clk) begin
        if (!rst) begin
            if (we_n && !we_p && lg_n < 64) begin
                lg_dat[lg_n] = dq_out; lg_cle[lg_n] = cle; lg_ale[lg_n] = ale;
                lg_n++;
                if (lo_run != LO_C) lo_bad++;
            end
            lo_run = we_n ? 0 : lo_run + 1;
            if (!ale && ale_p) ale_falls++;
            if (dq_oe) oe_cnt++;
            if (!re_n && re_p) re_lows++;
            if (re_n && !re_p) rd_idx++;
            if (rd_valid && rd_ready && rn < 16) begin rbuf[rn] = rd_data; rn++; end
            if (done) done_cyc++;
        end
        we_p = we_n; ale_p = ale; re_p = re_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0] wbuf [16];
    int acc_cyc = 0;

    task automatic run_op(input logic [2:0] code, input logic [2:0] chip,
                          input logic [7:0] arg, input int len, input int nfeed);
        @(negedge clk);
        op_code = code; op_chip = chip; op_arg = arg; op_len = 8'(len);
        op_valid = 1'b1;
        acc_cyc = cyc;
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < nfeed; i++) begin
            wr_data = wbuf[i]; wr_valid = 1'b1;
            while (!wr_ready) @(negedge clk);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // {chip index, expected ce_n}
    localparam logic [6:0] SEL_TAB [6] = '{
        {3'd2, 4'b1011}, {3'd5, 4'b1011}, {3'd0, 4'b1110},
        {3'd7, 4'b1110}, {3'd3, 4'b0111}, {3'd1, 4'b1101}
    };

    initial begin : watchdog
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int b, d0, o0, r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ce_n == 4'hF, "R1 ce_n", ce_n, 4'hF);
        chk({we_n, re_n, cle, ale, wp_n, dq_oe, op_ready} == 7'b1100001,
            "R1 strobes", {we_n, re_n, cle, ale, wp_n, dq_oe, op_ready}, 7'b1100001);

        // R2 select table
        for (int i = 0; i < 6; i++) begin
            run_op(3'd0, SEL_TAB[i][6:4], 8'h00, 0, 0);
            chk(ce_n == SEL_TAB[i][3:0], "R2 select", ce_n, SEL_TAB[i][3:0]);
        end
        run_op(3'd1, 3'd0, 8'h00, 0, 0);
        chk(ce_n == 4'hF, "R2 deselect", ce_n, 4'hF);

        // R3 ready combine
        for (int p = 0; p < 16; p += 5) begin
            rb_n = 4'(p); #1;
            chk(flash_ready == (p == 15), "R3 ready", flash_ready, p == 15);
        end
        rb_n = 4'hF; #1;
        chk(flash_ready == 1'b1, "R3 ready all", flash_ready, 1);

        // R4 command cycle
        b = lg_n; d0 = done_cyc; o0 = oe_cnt;
        run_op(3'd2, 3'd0, 8'h90, 0, 0);
        chk(lg_n - b == 1, "R4 one pulse", lg_n - b, 1);
        chk({lg_dat[b], lg_cle[b], lg_ale[b]} == {8'h90, 2'b10},
            "R4 byte/cle", {lg_dat[b], lg_cle[b], lg_ale[b]}, {8'h90, 2'b10});
        chk(!cle && !dq_oe, "R9 idle after cmd", {cle, dq_oe}, 0);
        chk(oe_cnt - o0 == 1 + LO_C + HI_C, "R12 drive window", oe_cnt - o0, 1 + LO_C + HI_C);
        chk(done_cyc - d0 == 1, "R11 done pulse", done_cyc - d0, 1);

        // R5 address burst
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        b = lg_n; d0 = ale_falls;
        run_op(3'd3, 3'd0, 8'h00, 3, 3);
        chk(lg_n - b == 3, "R5 count", lg_n - b, 3);
        for (int i = 0; i < 3; i++)
            chk({lg_dat[b+i], lg_cle[b+i], lg_ale[b+i]} == {wbuf[i], 2'b01},
                "R5 byte", lg_dat[b+i], wbuf[i]);
        chk(ale_falls - d0 == 1, "R5 single ale fall", ale_falls - d0, 1);

        // R6 empty address
        b = lg_n;
        run_op(3'd3, 3'd0, 8'h55, 0, 0);
        chk(lg_n - b == 1 && lg_dat[b] == 8'h00 && lg_ale[b], "R6 zero byte", lg_dat[b], 0);

        // R7 data write
        wbuf[0] = 8'hDE; wbuf[1] = 8'hAD; wbuf[2] = 8'hBE; wbuf[3] = 8'hEF;
        b = lg_n;
        run_op(3'd4, 3'd0, 8'h00, 4, 4);
        chk(lg_n - b == 4, "R7 count", lg_n - b, 4);
        for (int i = 0; i < 4; i++)
            chk({lg_dat[b+i], lg_cle[b+i], lg_ale[b+i]} == {wbuf[i], 2'b00},
                "R7 byte", lg_dat[b+i], wbuf[i]);

        // R8 data read with lagging sense
        b = lg_n; o0 = oe_cnt; r0 = re_lows; rn = 0; rd_idx = 0;
        @(negedge clk);
        op_code = 3'd5; op_len = 8'd3; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        chk(!op_ready, "R11 busy", op_ready, 0);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(rn == 3, "R8 byte count", rn, 3);
        for (int i = 0; i < 3; i++)
            chk(rbuf[i] == 8'hA0 + 8'(i), "R8 read byte", rbuf[i], 8'hA0 + i);
        chk(re_lows - r0 == 3, "R8 strobe count", re_lows - r0, 3);
        chk(lg_n == b, "R8 no write strobe", lg_n - b, 0);
        chk(oe_cnt == o0, "R9 driver off in read", oe_cnt - o0, 0);

        // R10 write-protect toggle with settle
        run_op(3'd6, 3'd0, 8'h00, 0, 0);
        chk(wp_n == 1'b1, "R10 wp released", wp_n, 1);
        chk(cyc - acc_cyc >= SETTLE, "R10 settle", cyc - acc_cyc, SETTLE);
        run_op(3'd6, 3'd0, 8'h00, 0, 0);
        chk(wp_n == 1'b0, "R10 wp asserted", wp_n, 0);

        // R11 no-op
        d0 = done_cyc; b = lg_n;
        run_op(3'd7, 3'd0, 8'h00, 0, 0);
        chk(done_cyc - d0 == 1 && lg_n == b && ce_n == 4'hF, "R11 nop", done_cyc - d0, 1);

        // R12 low phase width across all write pulses
        chk(lo_bad == 0, "R12 we low width", lo_bad, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule